// File: doc/BRIEF.md
# Adaptive Hebbian Pulse Synapse

This block is a single synapse of a spiking network. When a presynaptic spike arrives it emits a burst of single-cycle pulses on its output, one per clock, and the number of pulses equals the stored 4-bit weight. This replaces a multiplier with a down-counter. The soma downstream adds up pulse counts to get the weighted input.

The block also adapts its own weight. While a time-step is open it records whether the presynaptic input and the postsynaptic input were active. On the time-step boundary strobe it applies one of three local learning rules, chosen by a select input. The weight then moves by a learning-rate amount and saturates between zero and the maximum.

A load strobe writes a weight supplied from outside. That weight may be fixed or random. The current weight is always visible for readback.

Top module: `hebb_pulse_synapse`

## Requirements
- R1: After reset the weight reads 0, pulse_out is low and no activity is recorded.
- R2: When load_weight is high at a clock edge, weight_out equals init_weight after that edge. This takes precedence over a learning update at the same edge.
- R3: A pre_spike sampled at an edge loads a burst counter with the current weight. pulse_out is high for exactly that many consecutive cycles, starting after that edge. A weight of 0 gives no pulse.
- R4: A pre_spike that arrives during a burst restarts the count from the current weight. Pulses already emitted are not taken back.
- R5: A spike on either input counts as activity for the current time-step if it comes at any edge of the step, including the edge where step_tick is high. Recorded activity is cleared by that step_tick edge.
- R6: With rule_sel 0 (Hebb) or 3 (also Hebb), the weight rises by lr_step only when both inputs were active. Otherwise it is unchanged.
- R7: With rule_sel 1 (postsynaptic rule), the weight rises by lr_step when both inputs were active. It falls by lr_step when only the postsynaptic input was active.
- R8: With rule_sel 2 (presynaptic rule), the weight rises by lr_step when both inputs were active. It falls by lr_step when only the presynaptic input was active.
- R9: A rise saturates at 15 and a fall saturates at 0. The weight never wraps.
- R10: The weight changes only at an edge where step_tick and learn_en are both high, or where load_weight is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_spike | input | 1 | Presynaptic spike |
| post_spike | input | 1 | Postsynaptic spike |
| rule_sel | input | 2 | Learning rule: 0/3 Hebb, 1 postsynaptic, 2 presynaptic |
| learn_en | input | 1 | Enables weight adaptation at the time-step boundary |
| step_tick | input | 1 | Marks the last cycle of a time-step |
| lr_step | input | 3 | Learning-rate amount added or subtracted |
| init_weight | input | 4 | Weight to be loaded |
| load_weight | input | 1 | Load strobe for init_weight |
| pulse_out | output | 1 | Weighted pulse stream |
| weight_out | output | 4 | Current weight |

## Verification
The assertions check, on every cycle, the following properties:
- the weight holds between update points;
- a load writes exactly the offered value;
- the burst counter reloads on a spike and otherwise counts down by one;
- the Hebb setting never lowers the weight.

Some behaviour depends on history, so only the bench scenarios can show it:
- the exact pulse count of a burst and of a retriggered burst;
- activity gathered over several cycles of a time-step and cleared at the tick;
- the signed step under each rule and saturation at both limits.

These are compared with a reference function over random steps and directed corner cases.

// File: rtl/syn_pkg.sv
package syn_pkg;
    typedef enum logic [1:0] {
        RULE_HEBB     = 2'd0,
        RULE_POST     = 2'd1,
        RULE_PRE      = 2'd2,
        RULE_HEBB_ALT = 2'd3
    } rule_e;

    typedef struct packed {
        logic pre;
        logic post;
    } act_t;
endpackage

// File: rtl/syn_activity.sv
module syn_activity
    import syn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pre_spike,
    input  logic post_spike,
    input  logic step_tick,
    output act_t act
);
    act_t seen_d, seen_q;

    always_comb begin
        act.pre  = seen_q.pre  | pre_spike;
        act.post = seen_q.post | post_spike;
        seen_d   = step_tick ? '0 : act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

    // R5
    tick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick |=> (seen_q == '0));
    // R5
    spike_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_spike && !step_tick) |=> seen_q.pre);
endmodule

// File: rtl/syn_pulse_gen.sv
module syn_pulse_gen #(
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pre_spike,
    input  logic [WW-1:0] weight,
    output logic          pulse
);
    typedef struct packed {
        logic [WW-1:0] cnt;
    } pg_t;

    pg_t d, q;

    always_comb begin
        d = q;
        if (pre_spike)        d.cnt = weight;
        else if (q.cnt != '0) d.cnt = q.cnt - 1'b1;
        pulse = (q.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3 R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_spike |=> (q.cnt == $past(weight)));
    // R3
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_spike && q.cnt != '0) |=> (q.cnt == $past(q.cnt) - 1'b1));
    // R3
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_spike && q.cnt == '0) |=> !pulse);
endmodule

// File: rtl/syn_learn.sv
module syn_learn
    import syn_pkg::*;
#(
    parameter int WW  = 4,
    parameter int LRW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  act_t           act,
    input  rule_e          rule,
    input  logic           learn_en,
    input  logic           step_tick,
    input  logic [LRW-1:0] lr_step,
    input  logic [WW-1:0]  init_weight,
    input  logic           load_weight,
    output logic [WW-1:0]  weight
);
    localparam int SW = (WW > LRW ? WW : LRW) + 1;
    localparam logic [SW-1:0] WMAX = SW'((1 << WW) - 1);

    typedef struct packed {
        logic [WW-1:0] w;
    } ln_t;

    ln_t d, q;
    logic [SW-1:0] w_ext, lr_ext, up_val, dn_val;
    logic          inc, dec;

    always_comb begin
        w_ext  = SW'(q.w);
        lr_ext = SW'(lr_step);
        up_val = w_ext + lr_ext;
        if (up_val > WMAX) up_val = WMAX;
        dn_val = (w_ext < lr_ext) ? '0 : (w_ext - lr_ext);

        inc = act.pre && act.post;
        unique case (rule)
            RULE_POST: dec = act.post && !act.pre;
            RULE_PRE:  dec = act.pre  && !act.post;
            default:   dec = 1'b0;
        endcase

        d = q;
        if (load_weight)                 d.w = init_weight;
        else if (step_tick && learn_en) begin
            if (inc)      d.w = up_val[WW-1:0];
            else if (dec) d.w = dn_val[WW-1:0];
        end
        weight = q.w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10
    weight_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_weight && !(step_tick && learn_en)) |=> $stable(weight));
    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_weight |=> (weight == $past(init_weight)));
    // R6
    hebb_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_weight && (rule == RULE_HEBB || rule == RULE_HEBB_ALT))
        |=> (weight >= $past(weight)));
    // R6 R7 R8
    no_rise_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_weight && !(act.pre && act.post)) |=> (weight <= $past(weight)));
endmodule

// File: rtl/hebb_pulse_synapse.sv
module hebb_pulse_synapse
    import syn_pkg::*;
#(
    parameter int WW  = 4,
    parameter int LRW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre_spike,
    input  logic           post_spike,
    input  logic [1:0]     rule_sel,
    input  logic           learn_en,
    input  logic           step_tick,
    input  logic [LRW-1:0] lr_step,
    input  logic [WW-1:0]  init_weight,
    input  logic           load_weight,
    output logic           pulse_out,
    output logic [WW-1:0]  weight_out
);
    act_t  act;
    rule_e rule;

    assign rule = rule_e'(rule_sel);

    syn_activity u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_spike  (pre_spike),
        .post_spike (post_spike),
        .step_tick  (step_tick),
        .act        (act)
    );

    syn_learn #(.WW(WW), .LRW(LRW)) u_learn (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .rule        (rule),
        .learn_en    (learn_en),
        .step_tick   (step_tick),
        .lr_step     (lr_step),
        .init_weight (init_weight),
        .load_weight (load_weight),
        .weight      (weight_out)
    );

    syn_pulse_gen #(.WW(WW)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_spike (pre_spike),
        .weight    (weight_out),
        .pulse     (pulse_out)
    );
endmodule

// File: tb/hebb_pulse_synapse_test.sv
module hebb_pulse_synapse_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_spike = 1'b0, post_spike = 1'b0;
    logic [1:0] rule_sel = 2'd0;
    logic       learn_en = 1'b0, step_tick = 1'b0, load_weight = 1'b0;
    logic [2:0] lr_step = 3'd1;
    logic [3:0] init_weight = 4'd0;
    logic       pulse_out;
    logic [3:0] weight_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hebb_pulse_synapse uut (
        .clk(clk), .rst_n(rst_n), .pre_spike(pre_spike), .post_spike(post_spike),
        .rule_sel(rule_sel), .learn_en(learn_en), .step_tick(step_tick),
        .lr_step(lr_step), .init_weight(init_weight), .load_weight(load_weight),
        .pulse_out(pulse_out), .weight_out(weight_out)
    );

    function automatic int exp_w(int w, bit pre, bit post, int rule, int lr, bit en);
        int r;
        r = w;
        if (!en) return r;
        if (pre && post) r = w + lr;
        else if (rule == 1 && post) r = w - lr;
        else if (rule == 2 && pre) r = w - lr;
        if (r > 15) r = 15;
        if (r < 0) r = 0;
        return r;
    endfunction

    task automatic check(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // one clock: drive at negedge, sample shortly after posedge
    task automatic cyc(bit pre, bit post, bit tick, bit load, int iw);
        @(negedge clk);
        pre_spike = pre; post_spike = post; step_tick = tick;
        load_weight = load; init_weight = 4'(iw);
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic load(int w);
        cyc(0, 0, 0, 1, w);
        cyc(0, 0, 0, 0, 0);
    endtask

    // a step with one pre and one post choice, tick on the last cycle
    task automatic step(bit pre, bit post, int rule, int lr, bit en);
        rule_sel = 2'(rule); lr_step = 3'(lr); learn_en = en;
        cyc(pre, 0, 0, 0, 0);
        cyc(0, post, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
    endtask

    int burst;
    int w_exp;

    initial begin
        void'($urandom(1234));
        repeat (3) @(posedge clk);
        #1;
        // R1
        check("R1 weight", weight_out, 0);
        check("R1 pulse", pulse_out, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // R2
        load(9);
        check("R2 load", weight_out, 9);

        // R3 burst length equals weight
        cyc(1, 0, 0, 0, 0);
        burst = pulse_out;
        for (int i = 0; i < 20; i++) begin cyc(0, 0, 0, 0, 0); burst += pulse_out; end
        check("R3 burst 9", burst, 9);

        load(0);
        cyc(1, 0, 0, 0, 0);
        burst = pulse_out;
        for (int i = 0; i < 5; i++) begin cyc(0, 0, 0, 0, 0); burst += pulse_out; end
        check("R3 burst 0", burst, 0);

        // R4 retrigger
        load(5);
        cyc(1, 0, 0, 0, 0);
        burst = pulse_out;
        cyc(0, 0, 0, 0, 0); burst += pulse_out;
        cyc(0, 0, 0, 0, 0); burst += pulse_out;
        cyc(1, 0, 0, 0, 0); burst += pulse_out;
        for (int i = 0; i < 12; i++) begin cyc(0, 0, 0, 0, 0); burst += pulse_out; end
        check("R4 retrigger", burst, 8);

        // R6 Hebb rule
        load(4);
        step(1, 1, 0, 2, 1);
        check("R6 hebb both", weight_out, 6);
        step(1, 0, 0, 2, 1);
        check("R6 hebb pre only", weight_out, 6);
        step(1, 1, 3, 1, 1);
        check("R6 hebb alt code", weight_out, 7);

        // R7 postsynaptic rule
        step(0, 1, 1, 3, 1);
        check("R7 post only falls", weight_out, 4);
        step(1, 0, 1, 3, 1);
        check("R7 pre only holds", weight_out, 4);

        // R8 presynaptic rule
        step(1, 0, 2, 1, 1);
        check("R8 pre only falls", weight_out, 3);
        step(0, 1, 2, 1, 1);
        check("R8 post only holds", weight_out, 3);
        step(1, 1, 2, 2, 1);
        check("R8 both rises", weight_out, 5);

        // R9 saturation
        load(14);
        step(1, 1, 0, 3, 1);
        check("R9 top", weight_out, 15);
        load(2);
        step(0, 1, 1, 5, 1);
        check("R9 bottom", weight_out, 0);

        // R10 learn disabled / no tick
        load(6);
        step(1, 1, 0, 2, 0);
        check("R10 learn off", weight_out, 6);
        learn_en = 1; rule_sel = 0; lr_step = 2;
        cyc(1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        check("R10 no tick", weight_out, 6);
        // R5 activity from earlier cycles is still counted at this tick
        cyc(0, 0, 1, 0, 0);
        check("R5 gathered", weight_out, 8);
        // R5 cleared: next empty step changes nothing
        cyc(0, 0, 1, 0, 0);
        check("R5 cleared", weight_out, 8);
        // R5 spikes on the tick edge itself count
        cyc(1, 1, 1, 0, 0);
        check("R5 tick edge", weight_out, 10);

        // R2 precedence over update
        cyc(1, 1, 1, 1, 3);
        check("R2 load wins", weight_out, 3);
        cyc(0, 0, 1, 0, 0);
        idle(12);

        // random steps
        w_exp = 3;
        for (int s = 0; s < 60; s++) begin
            int len; int rl; int lr; bit en; bit pa; bit po; bit sp; bit so;
            len = 2 + int'($urandom_range(0, 4));
            rl = int'($urandom_range(0, 3));
            lr = int'($urandom_range(0, 7));
            en = ($urandom_range(0, 3) != 0);
            rule_sel = 2'(rl); lr_step = 3'(lr); learn_en = en;
            pa = 0; po = 0;
            if ($urandom_range(0, 9) == 0) begin
                int nw; nw = int'($urandom_range(0, 15));
                cyc(0, 0, 0, 1, nw);
                w_exp = nw;
            end
            for (int c = 0; c < len; c++) begin
                sp = ($urandom_range(0, 5) == 0);
                so = ($urandom_range(0, 5) == 0);
                pa |= sp; po |= so;
                cyc(sp, so, (c == len - 1), 0, 0);
            end
            w_exp = exp_w(w_exp, pa, po, rl, lr, en);
            check("R6 R7 R8 R9 random", weight_out, w_exp);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule